// File: doc/BRIEF.md
# Slow Infrared Baud Tick Generator

This block produces the timing strobes for a slow infrared asynchronous link. It runs from a 48 MHz clock. A fixed prescaler gives one enable every 26 clocks. A programmable 6-bit reload divider counts those enables and emits a 16x oversampling tick each time it reloads. A divide-by-16 stage on the oversampling tick produces the bit-rate tick. The resulting bit rate is 48 MHz / 26 / 16 / (n + 1), where n is the programmed count. The transmit and receive bit engines consume both ticks.

Software programs the divider count and a receive-timeout selector through a small write-only bus. A new count does not disturb the interval in progress: it waits until the divider next reloads, so no shortened tick is ever produced. The timeout stage is armed by the falling edge that starts a frame. It then counts bit ticks while the receive line stays high and fires a one-cycle event at a short or a long threshold. The same event returns the rate to the 9600 bit/s default.

Top module: `sir_baud_gen`

## Requirements
- R1: Consecutive `os_tick` pulses are exactly 26*(n+1) clocks apart when the active count is n. Each pulse lasts one cycle.
- R2: `bit_tick` pulses only in a cycle where `os_tick` is also high, once every 16 oversampling ticks. In steady state its spacing is 416*(n+1) clocks.
- R3: A write with `wr_sel`=0 loads the count from `wr_data[5:0]` and ignores the other data bits. After reset the active count is 11, which gives 9600 bit/s at 48 MHz.
- R4: A count written mid-interval leaves the current interval at the old length and applies from the next reload on. `active_cnt` changes only in a cycle where `os_tick` is high.
- R5: A write with `wr_sel`=1 loads the timeout selector from `wr_data[9:8]` (0 off, 1 short, 2 long). A write of 3 is ignored and keeps the previous selector. The selector is 0 after reset.
- R6: A falling edge on `rx_line` arms the timeout stage. Bit ticks that occur while `rx_line` is high are counted, and a low level clears the count. On the 4th counted tick (short) or the 8th (long), `rx_timeout` goes high for exactly one cycle, in the cycle after that bit tick, and the stage disarms.
- R7: With the selector at 0, `rx_timeout` never fires, however long the line stays idle.
- R8: A timeout event restores the count to 11 at the next divider reload. The oversampling interval after that reload is 312 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: rate register, 1: configuration register |
| wr_data | input | 16 | Write data |
| rx_line | input | 1 | Receive line, high when idle |
| os_tick | output | 1 | 16x oversampling strobe |
| bit_tick | output | 1 | Bit-rate strobe |
| rx_timeout | output | 1 | One-cycle receive-timeout event |
| active_cnt | output | 6 | Count the divider is currently using |
| to_sel | output | 2 | Current timeout selector |

## Verification
A corrupted down-counter or a wrong prescaler state shows up at the very next `os_tick`, as an interval that departs from 26*(n+1). A bad divide-by-16 phase appears within one bit period as a `bit_tick` spacing error. A count applied too early makes the interval that straddles a write come out short, and it also makes `active_cnt` move without an `os_tick`. A wrong arm or threshold state in the timeout stage moves the `rx_timeout` pulse by whole bit ticks. It can also suppress the pulse, or leave the count from the restore unapplied one oversampling interval after the event.

// File: rtl/sir_baud_pkg.sv
package sir_baud_pkg;

  typedef enum logic [1:0] {
    TO_OFF   = 2'd0,
    TO_SHORT = 2'd1,
    TO_LONG  = 2'd2,
    TO_RSVD  = 2'd3
  } to_sel_e;

  // count value that gives the requested bit rate
  function automatic int unsigned count_for_baud(input int unsigned clk_hz,
                                                 input int unsigned pre_div,
                                                 input int unsigned os_ratio,
                                                 input int unsigned baud);
    return clk_hz / pre_div / os_ratio / baud - 1;
  endfunction

  // clocks between oversampling ticks for a given count
  function automatic int unsigned os_period(input int unsigned pre_div,
                                            input int unsigned cnt);
    return pre_div * (cnt + 1);
  endfunction

endpackage

// File: rtl/sir_prescaler.sv
module sir_prescaler #(
  parameter int unsigned PRE_DIV = 26
) (
  input  logic clk,
  input  logic rst_n,
  output logic pre_en
);
  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pcnt;

  assign pre_en = (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (pre_en) pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end

  // R1: enable never on two adjacent cycles, counter stays in range
  p_pre_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en |=> !pre_en);
  p_pre_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= LAST);
endmodule

// File: rtl/sir_rate_div.sv
module sir_rate_div #(
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned OS_RATIO = 16,
  parameter logic [CNT_W-1:0] DEF_CNT = 6'd11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_en,
  input  logic             set_req,
  input  logic [CNT_W-1:0] set_val,
  output logic             os_tick,
  output logic             bit_tick,
  output logic [CNT_W-1:0] active_cnt
);
  localparam int unsigned SW = $clog2(OS_RATIO);
  localparam logic [SW-1:0] SUB_LAST = SW'(OS_RATIO - 1);

  logic [CNT_W-1:0] dcnt;
  logic [CNT_W-1:0] pend;
  logic             pend_v;
  logic [SW-1:0]    sub;
  logic             reload_evt;
  logic             bit_evt;
  logic [CNT_W-1:0] next_val;

  assign reload_evt = pre_en && (dcnt == '0);
  assign bit_evt    = reload_evt && (sub == SUB_LAST);

  always_comb begin
    if (set_req)     next_val = set_val;
    else if (pend_v) next_val = pend;
    else             next_val = active_cnt;
  end

  // staged value, held until the next reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= DEF_CNT;
      pend_v <= 1'b0;
    end else if (reload_evt) begin
      pend_v <= 1'b0;
    end else if (set_req) begin
      pend   <= set_val;
      pend_v <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt       <= DEF_CNT;
      active_cnt <= DEF_CNT;
    end else if (reload_evt) begin
      dcnt       <= next_val;
      active_cnt <= next_val;
    end else if (pre_en) begin
      dcnt <= dcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sub <= '0;
    else if (reload_evt) sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      os_tick  <= reload_evt;
      bit_tick <= bit_evt;
    end
  end

  // R1: an oversampling tick follows a prescaler enable
  p_tick_after_pre_r1: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> $past(pre_en));
  // R2: bit tick only together with an oversampling tick
  p_bit_in_os_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
  // R4: the count in use moves only at a reload
  p_cnt_at_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_cnt) |-> os_tick);
  // R4: the running counter never exceeds the count in use
  p_dcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= active_cnt);
endmodule

// File: rtl/sir_rx_timeout.sv
module sir_rx_timeout #(
  parameter int unsigned SHORT_BITS = 4,
  parameter int unsigned LONG_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       bit_tick,
  input  logic       rx_line,
  output logic       fire
);
  import sir_baud_pkg::*;
  localparam int unsigned TW = $clog2(LONG_BITS + 1);

  logic          rx_prev;
  logic          armed;
  logic [TW-1:0] tcnt;
  logic [TW-1:0] thr;
  logic          start_evt;
  logic          hit;

  always_comb begin
    case (to_sel_e'(sel))
      TO_SHORT: thr = TW'(SHORT_BITS);
      TO_LONG:  thr = TW'(LONG_BITS);
      default:  thr = '0;
    endcase
  end

  assign start_evt = rx_prev && !rx_line;
  assign hit = armed && rx_line && bit_tick && (thr != '0) && (tcnt == thr - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev <= 1'b1;
      armed   <= 1'b0;
      tcnt    <= '0;
      fire    <= 1'b0;
    end else begin
      rx_prev <= rx_line;
      fire    <= hit;
      if (thr == '0) begin
        armed <= 1'b0;
        tcnt  <= '0;
      end else if (start_evt) begin
        armed <= 1'b1;
        tcnt  <= '0;
      end else if (hit) begin
        armed <= 1'b0;
        tcnt  <= '0;
      end else if (armed && !rx_line) begin
        tcnt <= '0;
      end else if (armed && bit_tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R6: the event lasts one cycle and follows a bit tick
  p_fire_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  p_fire_after_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(bit_tick));
  // R7: a disabled stage stays disarmed
  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0) |=> !fire);
endmodule

// File: rtl/sir_baud_gen.sv
module sir_baud_gen #(
  parameter int unsigned CLK_HZ     = 48000000,
  parameter int unsigned PRE_DIV    = 26,
  parameter int unsigned OS_RATIO   = 16,
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned DEF_BAUD   = 9600,
  parameter int unsigned SHORT_BITS = 4,
  parameter int unsigned LONG_BITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [15:0]      wr_data,
  input  logic             rx_line,
  output logic             os_tick,
  output logic             bit_tick,
  output logic             rx_timeout,
  output logic [CNT_W-1:0] active_cnt,
  output logic [1:0]       to_sel
);
  import sir_baud_pkg::*;
  localparam logic [CNT_W-1:0] DEF_CNT =
    CNT_W'(count_for_baud(CLK_HZ, PRE_DIV, OS_RATIO, DEF_BAUD));
  localparam int unsigned TO_LSB = 8;

  logic             pre_en;
  logic             rate_wr;
  logic             cfg_wr;
  logic             set_req;
  logic [CNT_W-1:0] set_val;
  logic [1:0]       sel_in;

  assign rate_wr = wr_en && !wr_sel;
  assign cfg_wr  = wr_en &&  wr_sel;
  assign sel_in  = wr_data[TO_LSB+1:TO_LSB];

  // software write wins over the restore requested by a timeout
  assign set_req = rate_wr || rx_timeout;
  assign set_val = rate_wr ? wr_data[CNT_W-1:0] : DEF_CNT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              to_sel <= TO_OFF;
    else if (cfg_wr && sel_in != TO_RSVD)    to_sel <= sel_in;
  end

  sir_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en));

  sir_rate_div #(.CNT_W(CNT_W), .OS_RATIO(OS_RATIO), .DEF_CNT(DEF_CNT)) u_div (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en),
    .set_req(set_req), .set_val(set_val),
    .os_tick(os_tick), .bit_tick(bit_tick), .active_cnt(active_cnt));

  sir_rx_timeout #(.SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)) u_to (
    .clk(clk), .rst_n(rst_n), .sel(to_sel), .bit_tick(bit_tick),
    .rx_line(rx_line), .fire(rx_timeout));

  // R5: the reserved selector code is never held
  p_sel_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    to_sel != 2'd3);
  // R5: the selector changes only through a configuration write
  p_sel_by_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(to_sel) |-> $past(cfg_wr));
endmodule

// File: tb/sir_baud_gen_tb_top.sv
module sir_baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rx_line = 1'b1;
  logic        os_tick, bit_tick, rx_timeout;
  logic [5:0]  active_cnt;
  logic [1:0]  to_sel;

  int unsigned n_chk = 0, n_bad = 0;
  longint unsigned cyc = 0;
  bit done = 0;
  int unsigned os_q[$];
  int unsigned bit_q[$];
  longint unsigned os_last = 0, bit_last = 0;
  bit os_have = 0, bit_have = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sir_baud_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rx_line(rx_line), .os_tick(os_tick), .bit_tick(bit_tick),
    .rx_timeout(rx_timeout), .active_cnt(active_cnt), .to_sel(to_sel));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measure intervals and compare against queued expectations
  always @(negedge clk) begin
    if (rst_n && os_tick) begin
      if (os_have && os_q.size() > 0) begin
        int unsigned e;
        e = os_q.pop_front();
        chk((cyc - os_last) == e, "R1 os interval", cyc - os_last, e);
      end
      os_last = cyc; os_have = 1;
    end
    if (rst_n && bit_tick) begin
      if (bit_have && bit_q.size() > 0) begin
        int unsigned e;
        e = bit_q.pop_front();
        chk((cyc - bit_last) == e, "R2 bit interval", cyc - bit_last, e);
      end
      bit_last = cyc; bit_have = 1;
      chk(os_tick == 1'b1, "R2 bit with os", os_tick, 1);
    end
  end

  task automatic write_reg(input bit sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_os();
    do @(negedge clk); while (!os_tick);
  endtask

  task automatic wait_bit();
    do @(negedge clk); while (!bit_tick);
  endtask

  task automatic drain();
    while (os_q.size() > 0 || bit_q.size() > 0) @(negedge clk);
  endtask

  // expected oversampling interval, restated from R1
  function automatic int unsigned os_exp(input int unsigned n);
    return 26 * (n + 1);
  endfunction

  task automatic measure_rate(input int unsigned n, input bit with_bits);
    write_reg(1'b0, 16'(n));
    wait_os(); wait_os(); @(negedge clk);
    repeat (3) os_q.push_back(os_exp(n));
    if (with_bits) begin
      wait_bit(); @(negedge clk);
      repeat (2) bit_q.push_back(16 * os_exp(n));
    end
    drain();
  endtask

  // starts a frame, returns to idle, expects a timeout after thr counted bit ticks
  task automatic run_timeout(input int unsigned thr, input string req);
    int unsigned seen;
    bit got;
    seen = 0; got = 0;
    @(negedge clk); rx_line = 1'b0;
    repeat (3) @(negedge clk);
    // one bit tick while low must not count
    wait_bit();
    @(negedge clk); rx_line = 1'b1;
    while (!got && seen <= thr) begin
      @(negedge clk);
      if (rx_timeout) begin
        got = 1;
        chk(seen == thr, req, seen, thr);
      end
      if (bit_tick) seen++;
    end
    if (!got) chk(0, req, seen, thr);
    @(negedge clk);
    chk(rx_timeout == 1'b0, "R6 single pulse", rx_timeout, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // reset state
    chk(active_cnt == 6'd11, "R3 reset count", active_cnt, 11);
    chk(to_sel == 2'd0, "R5 reset selector", to_sel, 0);
    chk(os_tick == 1'b0 && rx_timeout == 1'b0, "R1 quiet in reset", os_tick, 0);
    rst_n = 1'b1;

    // default rate 9600: 312 clocks per os tick, 4992 per bit
    wait_os(); @(negedge clk);
    repeat (2) os_q.push_back(os_exp(11));
    wait_bit(); @(negedge clk);
    bit_q.push_back(16 * os_exp(11));
    drain();

    // several counts (R1, R2)
    measure_rate(0, 1'b1);
    measure_rate(3, 1'b0);
    measure_rate(63, 1'b0);

    // R3: upper data bits ignored: 0xFFC5 loads 5
    write_reg(1'b0, 16'hFFC5);
    wait_os(); wait_os(); @(negedge clk);
    chk(active_cnt == 6'd5, "R3 field mask", active_cnt, 5);
    os_q.push_back(os_exp(5));
    drain();

    // R4: mid-interval write
    write_reg(1'b0, 16'd11);
    wait_os(); wait_os(); @(negedge clk);
    os_q.push_back(os_exp(11));
    os_q.push_back(os_exp(3));
    os_q.push_back(os_exp(3));
    repeat (50) @(negedge clk);
    write_reg(1'b0, 16'd3);
    chk(active_cnt == 6'd11, "R4 held until reload", active_cnt, 11);
    drain();
    chk(active_cnt == 6'd3, "R4 applied after reload", active_cnt, 3);

    // R5: selector writes
    write_reg(1'b1, 16'h0100);
    @(negedge clk);
    chk(to_sel == 2'd1, "R5 selector short", to_sel, 1);
    write_reg(1'b1, 16'h0300);
    @(negedge clk);
    chk(to_sel == 2'd1, "R5 code 3 ignored", to_sel, 1);

    // R6 short threshold, then R8 restore
    write_reg(1'b0, 16'd0);
    wait_os(); wait_os();
    run_timeout(4, "R6 short threshold");
    wait_os();
    chk(active_cnt == 6'd11, "R8 restore count", active_cnt, 11);
    @(negedge clk);
    os_q.push_back(os_exp(11));
    drain();

    // R6 long threshold
    write_reg(1'b1, 16'h0200);
    write_reg(1'b0, 16'd0);
    wait_os(); wait_os();
    run_timeout(8, "R6 long threshold");

    // R7 off: no event over many idle bit ticks
    write_reg(1'b1, 16'h0000);
    write_reg(1'b0, 16'd0);
    wait_os(); wait_os();
    begin
      bit any;
      any = 0;
      @(negedge clk); rx_line = 1'b0;
      repeat (5) @(negedge clk);
      rx_line = 1'b1;
      repeat (16 * 416 * 3) begin
        @(negedge clk);
        if (rx_timeout) any = 1;
      end
      chk(any == 0, "R7 off never fires", any, 0);
      chk(active_cnt == 6'd0, "R7 count untouched", active_cnt, 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule